// File: doc/BRIEF.md
# Execute-to-Fetch Packet Packer

The packer takes a stream of execute packets and assembles them into fixed eight-slot fetch packets for a program-memory image. Each execute packet is a group of 1 to 8 operation words that issue together, and it arrives over a valid/ready handshake with a length field. Packets are placed whole and in arrival order into the fetch packet under construction. When an incoming packet does not fit in the slots that are still free, those slots are filled with NOP words and the packet under construction is emitted. The incoming packet then starts the next fetch packet.

Each emitted slot carries a parallel bit that marks whether the next slot belongs to the same execute packet. Padding NOPs extend the preceding execute packet and do not open a new one. A flush request closes a partly filled fetch packet at the end of a stream. Two saturating counters report how many fetch packets were emitted and how many padding NOPs were inserted. Together these show how well a schedule packs. For example, a steady run of five-wide execute packets wastes three slots per fetch packet, while four-wide packets pack two to a fetch packet with no waste.

Top module: `fp_packer`

## Requirements
- R1: After reset, fp_valid is 0, ep_ready is 1, and fp_total and pad_total are 0.
- R2: An accepted execute packet of ep_len words (ep_len from 1 to 8) is placed whole, never split. Operation i is taken from ep_ops[i*32 +: 32]. It goes into consecutive slots starting at the lowest free slot, and packets keep their arrival order. Slot s of a fetch packet appears on fp_ops[s*32 +: 32]. Words of ep_ops at and above ep_len are ignored.
- R3: When ep_len exceeds the free slots, the free slots are set to the NOP word (all zeros) and the partial fetch packet is emitted. The new execute packet begins at slot 0 of the next fetch packet.
- R4: An execute packet that fills the last free slot exactly causes the fetch packet to be emitted on the clock edge that accepts it, so fp_valid is 1 in the following cycle.
- R5: fp_par[s] is 1 exactly when slot s+1 belongs to the same execute packet. It is 0 on the last slot of each execute packet, on every padding slot and on slot 7.
- R6: A flush_req in a cycle with ep_valid low and no stalled output pads and emits a partly filled fetch packet. When the packet under construction is empty, a flush emits nothing.
- R7: While fp_valid is 1 and fp_ready is 0, ep_ready is 0 and fp_ops and fp_par stay unchanged.
- R8: When a length-8 execute packet arrives while the fetch packet under construction is partly filled, the padded packet is emitted first. The full length-8 packet is emitted on the next edge at which the output slot is free. ep_ready is 0 until then.
- R9: fp_total counts emitted fetch packets and pad_total counts inserted padding NOPs. Both saturate at 2^32-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_valid | input | 1 | Execute packet offered |
| ep_ready | output | 1 | Execute packet accepted this cycle when ep_valid is 1 |
| ep_len | input | 4 | Number of operations in the execute packet, 1 to 8 |
| ep_ops | input | 256 | Operation words, operation i in bits i*32 +: 32 |
| flush_req | input | 1 | Close the partial fetch packet (acted on with ep_valid low) |
| fp_valid | output | 1 | Fetch packet present on the output |
| fp_ready | input | 1 | Downstream takes the fetch packet |
| fp_ops | output | 256 | Fetch packet, slot s in bits s*32 +: 32 |
| fp_par | output | 8 | Per-slot parallel bits |
| fp_total | output | 32 | Saturating count of emitted fetch packets |
| pad_total | output | 32 | Saturating count of padding NOPs |

## Verification
The assertions assume that ep_len lies between 1 and 8 whenever an execute packet is accepted, and that a flush is requested only as a pulse or held level that the packer may sample at its own pace. The stimulus draws every length from that range. It leaves the words above the length random so that ignored inputs are visible. It raises flush only with ep_valid low and lets the reference model decide whether the flush was taken. Backpressure is applied at random and also held solid, so the stall and pending-full paths are reached without breaking these assumptions.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  // Reason a fetch packet leaves the assembly stage in a given cycle.
  typedef enum logic [2:0] {
    EMIT_NONE,
    EMIT_FULL,     // incoming packet completed the fetch packet exactly
    EMIT_PADDED,   // incoming packet did not fit, old one padded
    EMIT_FLUSH,    // end-of-stream close of a partial packet
    EMIT_PENDING   // deferred full packet after a padded emission
  } emit_cause_e;

endpackage

// File: rtl/fpk_assemble.sv
module fpk_assemble
  import fpk_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int OP_W  = 32,
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc,
  input  logic [LEN_W-1:0]      in_len,
  input  logic [SLOTS*OP_W-1:0] in_ops,
  input  logic                  flush_go,
  input  logic                  drain_ok,
  output logic                  emit,
  output logic [SLOTS*OP_W-1:0] emit_ops,
  output logic [SLOTS-1:0]      emit_par,
  output logic [LEN_W-1:0]      emit_pad,
  output logic                  full_wait
);

  localparam int VEC_W = SLOTS * OP_W;
  localparam int SUM_W = LEN_W + 1;

  logic [VEC_W-1:0] hold_ops, hold_ops_nx, ins_ops;
  logic [SLOTS-1:0] hold_par, hold_par_nx, ins_par;
  logic [LEN_W-1:0] fill, fill_nx, base;
  logic [SUM_W-1:0] fill_sum;
  logic             fits;
  emit_cause_e      cause;

  assign full_wait = (fill == LEN_W'(SLOTS));
  assign fill_sum  = {1'b0, fill} + {1'b0, in_len};
  assign fits      = (fill_sum <= SUM_W'(SLOTS));
  assign base      = fits ? fill : '0;

  // Shift the incoming operations up to the insertion base.
  always_comb begin : place_blk
    int rel;
    ins_ops = '0;
    ins_par = '0;
    for (int s = 0; s < SLOTS; s++) begin
      rel = s - int'(base);
      if (rel >= 0 && rel < int'(in_len)) begin
        ins_ops[s*OP_W +: OP_W] = in_ops[rel*OP_W +: OP_W];
        ins_par[s]              = (rel != int'(in_len) - 1);
      end
    end
  end

  always_comb begin : cause_blk
    if (full_wait && drain_ok)                          cause = EMIT_PENDING;
    else if (acc && fits && fill_sum == SUM_W'(SLOTS))  cause = EMIT_FULL;
    else if (acc && !fits)                              cause = EMIT_PADDED;
    else if (flush_go && fill != '0 && !full_wait)      cause = EMIT_FLUSH;
    else                                                cause = EMIT_NONE;
  end

  assign emit     = (cause != EMIT_NONE);
  assign emit_ops = (cause == EMIT_FULL) ? (hold_ops | ins_ops) : hold_ops;
  assign emit_par = (cause == EMIT_FULL) ? (hold_par | ins_par) : hold_par;
  assign emit_pad = (cause == EMIT_PADDED || cause == EMIT_FLUSH) ?
                    (LEN_W'(SLOTS) - fill) : '0;

  // Slots above the fill level are kept at zero, so padding costs no logic.
  always_comb begin : next_blk
    hold_ops_nx = hold_ops;
    hold_par_nx = hold_par;
    fill_nx     = fill;
    case (cause)
      EMIT_PENDING, EMIT_FULL, EMIT_FLUSH: begin
        hold_ops_nx = '0;
        hold_par_nx = '0;
        fill_nx     = '0;
      end
      EMIT_PADDED: begin
        hold_ops_nx = ins_ops;
        hold_par_nx = ins_par;
        fill_nx     = in_len;
      end
      default: begin
        if (acc) begin
          hold_ops_nx = hold_ops | ins_ops;
          hold_par_nx = hold_par | ins_par;
          fill_nx     = fill_sum[LEN_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ops <= '0;
      hold_par <= '0;
      fill     <= '0;
    end else begin
      hold_ops <= hold_ops_nx;
      hold_par <= hold_par_nx;
      fill     <= fill_nx;
    end
  end

  // R2: accepted lengths stay in the legal range (input assumption)
  len_legal_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> (in_len != '0 && in_len <= LEN_W'(SLOTS)));

  // R2
  fill_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= LEN_W'(SLOTS));

  // R3
  restart_slot0_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !fits) |=> (fill == $past(in_len)));

  // R6
  no_empty_emit_chk: assert property (@(posedge clk) disable iff (rst)
    emit |-> (emit_pad < LEN_W'(SLOTS)));

  // R8
  pending_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    full_wait |-> !acc);

endmodule

// File: rtl/fpk_stats.sv
module fpk_stats #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic [LEN_W-1:0] pad,
  output logic [CNT_W-1:0] fp_cnt,
  output logic [CNT_W-1:0] pad_cnt
);

  logic [CNT_W:0] pad_sum;

  assign pad_sum = {1'b0, pad_cnt} + (CNT_W + 1)'(pad);

  always_ff @(posedge clk) begin
    if (rst) begin
      fp_cnt  <= '0;
      pad_cnt <= '0;
    end else if (emit) begin
      if (fp_cnt != '1) fp_cnt <= fp_cnt + CNT_W'(1);
      pad_cnt <= pad_sum[CNT_W] ? '1 : pad_sum[CNT_W-1:0];
    end
  end

  // R9
  fp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (emit && fp_cnt != '1) |=> (fp_cnt == $past(fp_cnt) + CNT_W'(1)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !emit |=> ($stable(fp_cnt) && $stable(pad_cnt)));

  // R9
  pad_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    emit |=> (pad_cnt >= $past(pad_cnt)));

endmodule

// File: rtl/fpk_out_reg.sv
module fpk_out_reg #(
  parameter int SLOTS = 8,
  parameter int OP_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  emit,
  input  logic [SLOTS*OP_W-1:0] emit_ops,
  input  logic [SLOTS-1:0]      emit_par,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [SLOTS*OP_W-1:0] out_ops,
  output logic [SLOTS-1:0]      out_par,
  output logic                  can_emit
);

  assign can_emit = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ops   <= '0;
      out_par   <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_ops   <= emit_ops;
      out_par   <= emit_par;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ops) && $stable(out_par)));

  // R7
  emit_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    emit |-> can_emit);

  // R5
  last_par_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_par[SLOTS-1]);

endmodule

// File: rtl/fp_packer.sv
module fp_packer #(
  parameter int SLOTS = 8,
  parameter int OP_W  = 32,
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ep_valid,
  output logic                        ep_ready,
  input  logic [$clog2(SLOTS+1)-1:0]  ep_len,
  input  logic [SLOTS*OP_W-1:0]       ep_ops,
  input  logic                        flush_req,
  output logic                        fp_valid,
  input  logic                        fp_ready,
  output logic [SLOTS*OP_W-1:0]       fp_ops,
  output logic [SLOTS-1:0]            fp_par,
  output logic [CNT_W-1:0]            fp_total,
  output logic [CNT_W-1:0]            pad_total
);

  localparam int LEN_W = $clog2(SLOTS + 1);

  logic                  acc, flush_go, can_emit, full_wait, emit;
  logic [SLOTS*OP_W-1:0] emit_ops;
  logic [SLOTS-1:0]      emit_par;
  logic [LEN_W-1:0]      emit_pad;

  assign ep_ready = can_emit && !full_wait;
  assign acc      = ep_valid && ep_ready;
  assign flush_go = flush_req && !ep_valid && can_emit;

  fpk_assemble #(.SLOTS(SLOTS), .OP_W(OP_W), .LEN_W(LEN_W)) asm_i (
    .clk(clk), .rst(rst), .acc(acc), .in_len(ep_len), .in_ops(ep_ops),
    .flush_go(flush_go), .drain_ok(can_emit), .emit(emit),
    .emit_ops(emit_ops), .emit_par(emit_par), .emit_pad(emit_pad),
    .full_wait(full_wait)
  );

  fpk_out_reg #(.SLOTS(SLOTS), .OP_W(OP_W)) out_i (
    .clk(clk), .rst(rst), .emit(emit), .emit_ops(emit_ops),
    .emit_par(emit_par), .out_ready(fp_ready), .out_valid(fp_valid),
    .out_ops(fp_ops), .out_par(fp_par), .can_emit(can_emit)
  );

  fpk_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W)) stats_i (
    .clk(clk), .rst(rst), .emit(emit), .pad(emit_pad),
    .fp_cnt(fp_total), .pad_cnt(pad_total)
  );

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fp_valid && !fp_ready) |-> !ep_ready);

endmodule

// File: tb/fp_packer_tb_top.sv
module fp_packer_tb_top;
  localparam int SLOTS = 8;
  localparam int OP_W  = 32;
  localparam int LEN_W = 4;
  localparam int VEC_W = SLOTS * OP_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ep_valid = 1'b0, ep_ready;
  logic [LEN_W-1:0] ep_len = '0;
  logic [VEC_W-1:0] ep_ops = '0;
  logic             flush_req = 1'b0;
  logic             fp_valid, fp_ready = 1'b1;
  logic [VEC_W-1:0] fp_ops;
  logic [SLOTS-1:0] fp_par;
  logic [31:0]      fp_total, pad_total;

  always #10 clk = ~clk;

  fp_packer dut_i (
    .clk(clk), .rst(rst), .ep_valid(ep_valid), .ep_ready(ep_ready),
    .ep_len(ep_len), .ep_ops(ep_ops), .flush_req(flush_req),
    .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_ops(fp_ops),
    .fp_par(fp_par), .fp_total(fp_total), .pad_total(pad_total)
  );

  int n_chk = 0, n_err = 0, cyc = 0, or_mode = 0, ep_id = 1;

  // Behavioural reference: slot arrays and counts.
  int              m_fill;
  logic [OP_W-1:0] m_bo[SLOTS], m_oo[SLOTS];
  bit              m_bp[SLOTS], m_op[SLOTS];
  bit              m_ov;
  longint          m_fp, m_nop;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < SLOTS; i++) begin m_bo[i] = '0; m_bp[i] = 0; end
    m_fill = 0;
  endtask

  task automatic m_emit(int pad);
    for (int i = 0; i < SLOTS; i++) begin m_oo[i] = m_bo[i]; m_op[i] = m_bp[i]; end
    m_ov = 1; m_fp++; m_nop += pad;
    m_clear();
  endtask

  task automatic m_place(int at, int len);
    for (int i = 0; i < len; i++) begin
      m_bo[at+i] = ep_ops[i*OP_W +: OP_W];
      m_bp[at+i] = (i < len - 1);
    end
    m_fill = at + len;
  endtask

  task automatic m_step();
    bit can, rdy;
    int len;
    can = !m_ov || fp_ready;
    rdy = can && (m_fill != SLOTS);
    len = int'(ep_len);
    if (m_ov && fp_ready) m_ov = 0;
    if (m_fill == SLOTS && can) m_emit(0);
    else if (ep_valid && rdy) begin
      if (m_fill + len <= SLOTS) begin
        m_place(m_fill, len);
        if (m_fill == SLOTS) m_emit(0);
      end else begin
        m_emit(SLOTS - m_fill);
        m_place(0, len);
      end
    end else if (flush_req && !ep_valid && can && m_fill > 0) m_emit(SLOTS - m_fill);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_clear(); m_ov = 0; m_fp = 0; m_nop = 0;
      for (int i = 0; i < SLOTS; i++) begin m_oo[i] = '0; m_op[i] = 0; end
    end else m_step();
  end

  // Per-cycle comparison, well away from both clock edges.
  always begin
    @(negedge clk); #5;
    if (!rst) begin
      chk("R2 fp_valid", fp_valid, m_ov);
      if (m_ov) begin
        for (int s = 0; s < SLOTS; s++) begin
          chk("R2/R3 slot word", fp_ops[s*OP_W +: OP_W], m_oo[s]);
          chk("R5 parallel bit", fp_par[s], m_op[s]);
        end
      end
      chk("R7 ep_ready", ep_ready, (!m_ov || fp_ready) && m_fill != SLOTS);
      chk("R9 fp_total", fp_total, m_fp);
      chk("R9 pad_total", pad_total, m_nop);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d cycles expected<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [VEC_W-1:0] mk_ops(int len);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < SLOTS; i++)
      v[i*OP_W +: OP_W] = (i < len) ? {ep_id[15:0], 8'(i), 8'h5A} : $urandom;
    return v;
  endfunction

  task automatic step(bit v, int len, logic [VEC_W-1:0] ops, bit fl, output bit a);
    @(negedge clk);
    fp_ready  = (or_mode == 0) ? 1'b1 : (or_mode == 2) ? 1'b0 : ($urandom_range(0, 2) != 0);
    ep_valid  = v;
    ep_len    = LEN_W'(len);
    ep_ops    = ops;
    flush_req = fl;
    #1;
    a = v && ep_ready;
  endtask

  task automatic send(int len);
    bit a;
    logic [VEC_W-1:0] ops;
    ops = mk_ops(len);
    do step(1, len, ops, 0, a); while (!a);
    ep_id++;
  endtask

  task automatic idle();
    bit a;
    step(0, 0, '0, 0, a);
  endtask

  task automatic flush();
    bit a;
    step(0, 0, '0, 1, a);
  endtask

  initial begin
    bit a;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    // R1 reset state
    chk("R1 fp_valid", fp_valid, 0);
    chk("R1 ep_ready", ep_ready, 1);
    chk("R1 fp_total", fp_total, 0);
    chk("R1 pad_total", pad_total, 0);

    // R4: two four-wide packets fill exactly
    send(4); send(4); idle(); #2;
    chk("R4 fp_valid after exact fill", fp_valid, 1);
    chk("R5 par pattern two x4", fp_par, 8'h77);
    chk("R4 fp_total", fp_total, 1);
    chk("R4 pad_total", pad_total, 0);

    // R3 and R6: five-wide stream, then flush
    send(5); send(5); send(5); flush(); idle(); #2;
    chk("R3 fp_total x5 stream", fp_total, 4);
    chk("R3 pad_total x5 stream", pad_total, 9);
    chk("R3 pad slot is NOP", fp_ops[5*OP_W +: OP_W], 0);
    chk("R5 par on padded packet", fp_par, 8'h0F);

    // R6: flush of an empty packet emits nothing
    flush(); idle(); #2;
    chk("R6 empty flush fp_valid", fp_valid, 0);
    chk("R6 empty flush fp_total", fp_total, 4);

    // R8: three then eight
    send(3); send(8); idle(); #2;
    chk("R8 ep_ready low while full pending", ep_ready, 0);
    chk("R8 pad_total", pad_total, 14);
    chk("R8 fp_total first", fp_total, 5);
    idle(); #2;
    chk("R8 fp_total second", fp_total, 6);
    chk("R8 full packet par", fp_par, 8'h7F);
    chk("R8 slot 7 word", fp_ops[7*OP_W +: OP_W], {16'(ep_id - 1), 8'd7, 8'h5A});

    // R7: solid backpressure
    idle(); idle();
    or_mode = 2;
    send(8);
    step(1, 2, mk_ops(2), 0, a);
    chk("R7 blocked while stalled", a, 0);
    step(1, 2, mk_ops(2), 0, a);
    chk("R7 still blocked", a, 0);
    chk("R7 held packet valid", fp_valid, 1);
    or_mode = 0;
    send(2); flush(); idle(); idle();

    // Random lengths with random stalls
    or_mode = 1;
    for (int k = 0; k < 300; k++) begin
      int r;
      r = $urandom_range(0, 34);
      if (r % 7 == 0) flush();
      else if (r % 5 == 0) idle();
      send($urandom_range(1, 8));
    end
    or_mode = 0;
    flush(); idle(); idle(); idle();
    #2;
    chk("R9 final fp_total", fp_total, m_fp);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule